// File: doc/BRIEF.md
# Serial Transmit Start and Frame-Sync Controller

This block decides the moment a synchronous serial transmitter begins shifting out a word, and it produces a periodic frame-sync pulse from the transmit bit clock. A software-style configuration supplies three fields: a frame-sync period, a post-trigger start delay and a start-source selector. The source can be continuous data flow, the receiver's own start, a level on the external frame-sync input, an edge on that input, or any change of it.

All sequencing advances only on clock cycles where the transmit clock enable `tck_en` is high. The surrounding transmitter (data shifter, clock generation and bus interface) is represented by single-cycle strobes: a word was written, the current word has finished, and the receiver has started. The controller answers with a one-cycle start pulse and a frame-sync output. The external frame-sync input passes through a two-flop synchronizer. Its previous value is kept on each enabled cycle so that edges can be detected.

Top module: `txstart_ctrl`

## Requirements
- R1: During and right after synchronous reset, `start_pulse` and `fs_out` are low.
- R2: With `cfg_period` = 0, `fs_out` stays low.
- R3: With `cfg_period` = P > 0 and `tx_en` high, `fs_out` rises on the first enabled edge after the divider starts from zero. It then rises again every 2*(P+1) enabled edges, and each pulse lasts one enable interval.
- R4: Source code 0 (continuous) starts a word on the enabled edge where a write strobe is seen or a write is pending and no transfer is active. When a transfer ends with a write pending, the next start follows on the next enabled edge. With nothing pending, no start follows.
- R5: Source code 1 starts on an enabled edge where `rx_start` is high. The start delay applies in this mode too.
- R6: Source code 2 starts while the synchronized frame-sync input is low, and code 3 while it is high.
- R7: Source code 4 starts on a synchronized falling edge of `fs_in`, and code 5 on a rising edge. A change of `fs_in` before clock edge k is acted on at edge k+2.
- R8: Source codes 6 and 7 start on either direction of change of the synchronized `fs_in`.
- R9: With `cfg_delay` = D, the start pulse follows the accepting edge by D enabled edges (0 means the same edge). The pulse is one clock wide.
- R10: A trigger is ignored while a delay countdown runs or a transfer is active. A transfer is active from the start pulse until `word_done`.
- R11: Source codes 8 to 15 never produce a start pulse.
- R12: While `tx_en` is low, the delay counter, transfer state, pending write and frame-sync divider are all cleared. An aborted countdown then never produces a pulse, and the divider restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tck_en | input | 1 | Transmit clock enable, one cycle per bit clock |
| tx_en | input | 1 | Transmitter enabled |
| word_wr | input | 1 | Strobe: a word was written for transmission |
| word_done | input | 1 | Strobe: the word being shifted has finished |
| rx_start | input | 1 | Strobe: the receiver started |
| fs_in | input | 1 | External frame-sync input, asynchronous |
| cfg_period | input | 8 | Frame-sync period field, 0 disables |
| cfg_delay | input | 8 | Start delay in enabled cycles |
| cfg_src | input | 4 | Start-source selector |
| start_pulse | output | 1 | One-cycle start-transmission pulse |
| fs_out | output | 1 | Generated periodic frame-sync pulse |

## Verification
The bench targets three timing points: the delay countdown (an off-by-one design pulses one cycle early or late), the two-cycle synchronizer latency on edge modes, and the divider length of 2*(P+1). A wrong divider would space the frame-sync pulses by P or P+1 instead. Other cases it covers:
- triggers arriving during a countdown or an active transfer, which a faulty design would take up as extra starts;
- continuous restart with and without a pending write, where the faulty version stalls or starts spuriously;
- a countdown aborted by disabling the transmitter, which a design without the clear would later complete;
- reserved selector codes, which must stay silent.

// File: rtl/txs_pkg.sv
package txs_pkg;
  localparam int SEL_W = 4;

  typedef enum logic [SEL_W-1:0] {
    SRC_CONT   = 4'd0,
    SRC_RXSTRT = 4'd1,
    SRC_LOW    = 4'd2,
    SRC_HIGH   = 4'd3,
    SRC_FALL   = 4'd4,
    SRC_RISE   = 4'd5,
    SRC_CHANGE = 4'd6,
    SRC_EDGE   = 4'd7
  } src_e;
endpackage

// File: rtl/txs_trig_detect.sv
module txs_trig_detect
  import txs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tck_en,
  input  logic             fs_in,
  input  logic [SEL_W-1:0] sel,
  input  logic             rx_start,
  input  logic             data_avail,
  output logic             trig
);
  logic sync1, sync2, prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      prev  <= 1'b0;
    end else begin
      sync1 <= fs_in;
      sync2 <= sync1;
      if (tck_en) prev <= sync2;
    end
  end

  always_comb begin
    case (sel)
      SRC_CONT:   trig = data_avail;
      SRC_RXSTRT: trig = rx_start;
      SRC_LOW:    trig = !sync2;
      SRC_HIGH:   trig = sync2;
      SRC_FALL:   trig = prev && !sync2;
      SRC_RISE:   trig = !prev && sync2;
      SRC_CHANGE,
      SRC_EDGE:   trig = prev ^ sync2;
      default:    trig = 1'b0;
    endcase
  end
endmodule

// File: rtl/txs_start_seq.sv
module txs_start_seq #(
  parameter int DELAY_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tck_en,
  input  logic               tx_en,
  input  logic               trig,
  input  logic [DELAY_W-1:0] cfg_delay,
  input  logic               word_done,
  output logic               accept,
  output logic               start_pulse,
  output logic               busy,
  output logic               waiting
);
  logic [DELAY_W-1:0] cnt;
  logic               idle;

  assign idle   = !busy && !waiting;
  assign accept = tck_en && tx_en && trig && idle;

  always_ff @(posedge clk) begin
    if (rst || !tx_en) begin
      cnt         <= '0;
      waiting     <= 1'b0;
      busy        <= 1'b0;
      start_pulse <= 1'b0;
    end else begin
      start_pulse <= 1'b0;
      if (word_done) busy <= 1'b0;
      if (tck_en) begin
        if (accept) begin
          if (cfg_delay == '0) begin
            start_pulse <= 1'b1;
            busy        <= 1'b1;
          end else begin
            cnt     <= cfg_delay;
            waiting <= 1'b1;
          end
        end else if (waiting) begin
          if (cnt == DELAY_W'(1)) begin
            start_pulse <= 1'b1;
            busy        <= 1'b1;
            waiting     <= 1'b0;
            cnt         <= '0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/txs_fs_gen.sv
module txs_fs_gen #(
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tck_en,
  input  logic                tx_en,
  input  logic [PERIOD_W-1:0] cfg_period,
  output logic                fs_out
);
  localparam int CNT_W = PERIOD_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  // 2*(P+1)-1 equals P with a one appended below it
  assign last = {cfg_period, 1'b1};

  always_ff @(posedge clk) begin
    if (rst || !tx_en) begin
      cnt    <= '0;
      fs_out <= 1'b0;
    end else if (tck_en) begin
      if (cfg_period == '0) begin
        cnt    <= '0;
        fs_out <= 1'b0;
      end else begin
        fs_out <= (cnt == '0);
        cnt    <= (cnt == last) ? '0 : cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/txstart_ctrl.sv
module txstart_ctrl
  import txs_pkg::*;
#(
  parameter int PERIOD_W = 8,
  parameter int DELAY_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tck_en,
  input  logic                tx_en,
  input  logic                word_wr,
  input  logic                word_done,
  input  logic                rx_start,
  input  logic                fs_in,
  input  logic [PERIOD_W-1:0] cfg_period,
  input  logic [DELAY_W-1:0]  cfg_delay,
  input  logic [SEL_W-1:0]    cfg_src,
  output logic                start_pulse,
  output logic                fs_out
);
  logic pending;
  logic data_avail;
  logic trig;
  logic accept;
  logic xfer_busy;
  logic waiting;

  assign data_avail = pending || word_wr;

  always_ff @(posedge clk) begin
    if (rst || !tx_en) begin
      pending <= 1'b0;
    end else if (accept && cfg_src == SRC_CONT) begin
      pending <= 1'b0;
    end else if (word_wr) begin
      pending <= 1'b1;
    end
  end

  txs_trig_detect u_detect (
    .clk        (clk),
    .rst        (rst),
    .tck_en     (tck_en),
    .fs_in      (fs_in),
    .sel        (cfg_src),
    .rx_start   (rx_start),
    .data_avail (data_avail),
    .trig       (trig)
  );

  txs_start_seq #(.DELAY_W(DELAY_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .tck_en      (tck_en),
    .tx_en       (tx_en),
    .trig        (trig),
    .cfg_delay   (cfg_delay),
    .word_done   (word_done),
    .accept      (accept),
    .start_pulse (start_pulse),
    .busy        (xfer_busy),
    .waiting     (waiting)
  );

  txs_fs_gen #(.PERIOD_W(PERIOD_W)) u_fsgen (
    .clk        (clk),
    .rst        (rst),
    .tck_en     (tck_en),
    .tx_en      (tx_en),
    .cfg_period (cfg_period),
    .fs_out     (fs_out)
  );
endmodule

// File: rtl/txs_checker.sv
module txs_checker #(
  parameter int PERIOD_W = 8,
  parameter int SEL_W    = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                tck_en,
  input logic                tx_en,
  input logic                word_done,
  input logic [PERIOD_W-1:0] cfg_period,
  input logic [SEL_W-1:0]    cfg_src,
  input logic                start_pulse,
  input logic                fs_out,
  input logic                xfer_busy,
  input logic                waiting
);
  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (rst)
    start_pulse |=> !start_pulse);

  assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (rst)
    (xfer_busy && !word_done && tx_en) |=> !start_pulse);

  assert_zero_period_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_period == '0 && tck_en) |=> !fs_out);

  assert_disable_clears_R12: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (!start_pulse && !fs_out && !xfer_busy && !waiting));

  assert_reserved_silent_R11: assert property (@(posedge clk) disable iff (rst)
    (cfg_src[SEL_W-1] && !waiting) |=> !start_pulse);
endmodule

bind txstart_ctrl txs_checker #(.PERIOD_W(PERIOD_W), .SEL_W(txs_pkg::SEL_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tck_en      (tck_en),
  .tx_en       (tx_en),
  .word_done   (word_done),
  .cfg_period  (cfg_period),
  .cfg_src     (cfg_src),
  .start_pulse (start_pulse),
  .fs_out      (fs_out),
  .xfer_busy   (xfer_busy),
  .waiting     (waiting)
);

// File: tb/tb_txstart_ctrl.sv
`timescale 1ns/1ps
module tb_txstart_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tck_en = 1'b1;
  logic       tx_en = 1'b0;
  logic       word_wr = 1'b0;
  logic       word_done = 1'b0;
  logic       rx_start = 1'b0;
  logic       fs_in = 1'b0;
  logic [7:0] cfg_period = 8'd0;
  logic [7:0] cfg_delay = 8'd0;
  logic [3:0] cfg_src = 4'd8;
  logic       start_pulse;
  logic       fs_out;

  int    checks = 0;
  int    failures = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  string phase = "R1";
  int    exp_s[$];
  string tag_s[$];
  int    exp_f[$];
  string tag_f[$];
  logic  fs_last = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  txstart_ctrl dut (
    .clk(clk), .rst(rst), .tck_en(tck_en), .tx_en(tx_en),
    .word_wr(word_wr), .word_done(word_done), .rx_start(rx_start),
    .fs_in(fs_in), .cfg_period(cfg_period), .cfg_delay(cfg_delay),
    .cfg_src(cfg_src), .start_pulse(start_pulse), .fs_out(fs_out)
  );

  // monitor: compare observed pulses with queued expectations
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (start_pulse) begin
        checks++;
        if (exp_s.size() == 0) begin
          failures++;
          $display("FAIL %s: start pulse at cycle %0d, expected none", phase, cyc);
        end else begin
          int e;
          string t;
          e = exp_s.pop_front();
          t = tag_s.pop_front();
          if (e != cyc) begin
            failures++;
            $display("FAIL %s: start pulse at cycle %0d, expected %0d", t, cyc, e);
          end
        end
      end
      if (fs_out && !fs_last) begin
        checks++;
        if (exp_f.size() == 0) begin
          failures++;
          $display("FAIL %s: frame sync at cycle %0d, expected none", phase, cyc);
        end else begin
          int e;
          string t;
          e = exp_f.pop_front();
          t = tag_f.pop_front();
          if (e != cyc) begin
            failures++;
            $display("FAIL %s: frame sync at cycle %0d, expected %0d", t, cyc, e);
          end
        end
      end
    end
    fs_last <= fs_out;
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_s(int c, string t);
    exp_s.push_back(c);
    tag_s.push_back(t);
  endtask

  task automatic push_f(int c, string t);
    exp_f.push_back(c);
    tag_f.push_back(t);
  endtask

  task automatic drained(string t);
    checks++;
    if (exp_s.size() != 0 || exp_f.size() != 0) begin
      failures++;
      $display("FAIL %s: %0d start and %0d frame-sync pulses missing, expected 0",
               t, exp_s.size(), exp_f.size());
      exp_s.delete(); tag_s.delete(); exp_f.delete(); tag_f.delete();
    end
  endtask

  task automatic strobe_done();
    word_done = 1'b1; step(1); word_done = 1'b0; step(2);
  endtask

  initial begin
    step(4);
    checks++;
    if (start_pulse !== 1'b0 || fs_out !== 1'b0) begin
      failures++;
      $display("FAIL R1: outputs %b%b in reset, expected 00", start_pulse, fs_out);
    end
    rst = 1'b0;
    tx_en = 1'b1;
    step(4);
    checks++;
    if (start_pulse !== 1'b0 || fs_out !== 1'b0) begin
      failures++;
      $display("FAIL R1: outputs %b%b after reset, expected 00", start_pulse, fs_out);
    end

    // R4 continuous mode
    phase = "R4";
    cfg_src = 4'd0; word_wr = 1'b1; push_s(cyc + 1, "R4");
    step(1); word_wr = 1'b0;
    step(2);
    word_wr = 1'b1; step(1); word_wr = 1'b0;     // pending while busy
    step(3);
    word_done = 1'b1; push_s(cyc + 2, "R4");
    step(1); word_done = 1'b0;
    step(4);
    strobe_done();                               // nothing pending: no restart
    step(4);
    drained("R4");
    cfg_src = 4'd8; step(2);

    // R5 and R9 receiver start with delay 3, R10 retrigger ignored
    phase = "R5";
    cfg_src = 4'd1; cfg_delay = 8'd3; step(1);
    rx_start = 1'b1; push_s(cyc + 4, "R5_R9");
    step(1); rx_start = 1'b0;
    rx_start = 1'b1; step(1); rx_start = 1'b0;   // r10_ during countdown
    step(3);
    phase = "R10";
    rx_start = 1'b1; step(1); rx_start = 1'b0;   // during transfer
    step(3);
    drained("R10");
    cfg_src = 4'd8; cfg_delay = 8'd0; strobe_done();

    // R6 level modes
    phase = "R6";
    cfg_src = 4'd2; push_s(cyc + 1, "R6_low");
    step(1); cfg_src = 4'd8; step(2); strobe_done();
    fs_in = 1'b1; step(4);
    cfg_src = 4'd3; push_s(cyc + 1, "R6_high");
    step(1); cfg_src = 4'd8; step(2); strobe_done();
    drained("R6");

    // R7 edge modes (fs_in high here)
    phase = "R7";
    cfg_src = 4'd4; step(2);
    fs_in = 1'b0; push_s(cyc + 3, "R7_fall");
    step(6); cfg_src = 4'd8; strobe_done();
    cfg_src = 4'd5; step(2);
    fs_in = 1'b1; push_s(cyc + 3, "R7_rise");
    step(6);
    fs_in = 1'b0; step(4); fs_in = 1'b1; step(6); // R10: busy, ignored
    drained("R7");
    cfg_src = 4'd8; strobe_done();

    // R8 any change (fs_in high here)
    phase = "R8";
    cfg_src = 4'd6; step(2);
    fs_in = 1'b0; push_s(cyc + 3, "R8_fall");
    step(6); cfg_src = 4'd8; strobe_done();
    cfg_src = 4'd7; step(2);
    fs_in = 1'b1; push_s(cyc + 3, "R8_rise");
    step(6); cfg_src = 4'd8; strobe_done();
    drained("R8");

    // R9 delay 1 on rising edge
    phase = "R9";
    cfg_src = 4'd5; cfg_delay = 8'd1; fs_in = 1'b0; step(4);
    fs_in = 1'b1; push_s(cyc + 4, "R9");
    step(8); cfg_src = 4'd8; cfg_delay = 8'd0; strobe_done();
    drained("R9");

    // R11 reserved codes
    phase = "R11";
    for (int s = 8; s < 16; s++) begin
      cfg_src = 4'(s);
      fs_in = ~fs_in; word_wr = 1'b1; rx_start = 1'b1;
      step(1); word_wr = 1'b0; rx_start = 1'b0;
      step(4);
    end
    drained("R11");
    tx_en = 1'b0; step(1); tx_en = 1'b1; step(1);  // drop pending writes

    // R12 aborted countdown
    phase = "R12";
    fs_in = 1'b0; step(4);
    cfg_src = 4'd5; cfg_delay = 8'd10; step(2);
    fs_in = 1'b1; step(5);
    tx_en = 1'b0; step(2); tx_en = 1'b1; step(20);
    drained("R12");
    cfg_src = 4'd8; cfg_delay = 8'd0; step(2);

    // R3 frame-sync divider, P=2 spacing 6
    phase = "R3";
    cfg_period = 8'd2;
    push_f(cyc + 1, "R3"); push_f(cyc + 7, "R3"); push_f(cyc + 13, "R3");
    step(16);
    cfg_period = 8'd0;
    step(2);
    drained("R3");

    // R2 zero period
    phase = "R2";
    step(30);
    drained("R2");

    // R12 divider restart after disable, P=1 spacing 4
    phase = "R12";
    cfg_period = 8'd1;
    push_f(cyc + 1, "R12"); push_f(cyc + 5, "R12");
    step(6);
    tx_en = 1'b0; step(3);
    tx_en = 1'b1; push_f(cyc + 1, "R12");
    step(2);
    cfg_period = 8'd0; step(4);
    drained("R12");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule